// File: doc/BRIEF.md
# Dirty-Line Writeback Walker

This block sits beside a write-back data cache and makes stored code visible to instruction fetch. When a fetch-synchronisation request rises, it visits every line of the cache, set after set, and every way within a set. For each line whose dirty bit is set, it sends one write to memory, waits for memory to confirm the write, and then clears that line's dirty bit.

The dirty bits are kept in flip-flops inside the block, so the dirty state of any set can be read in the same cycle. The cache store path sets a bit with a one-cycle mark strobe. The block does not hold the tag store. It drives the set index it is visiting, and the tag store returns the tags of all ways of that set. The block joins the tag of the chosen way with the set index to form the line address.

While the walk runs, the block raises a pipeline stall that overrides every other stall cause. It also holds back any tag-invalidate write until all dirty data has reached memory.

Top module: `dline_flush_seq`

## Requirements
- R1: After reset the block is idle: `stall_fence`, `flush_active`, `wb_req` and `clr_vld` are all 0, `stall_kind` is 0, and every dirty bit is clear.
- R2: A walk starts only on a 0-to-1 change of `sync_req` between two cycles. A request held high after a walk has finished does not start another walk.
- R3: A walk issues exactly one writeback for each dirty line and none for clean lines. Sets are visited in ascending order, and within a set the ways are visited in ascending order.
- R4: `wb_addr` is `{tag, set, OFF_W zero bits}`. The tag is the way's slice `tag_rows[way*TAG_W +: TAG_W]` of the tag row selected by `tag_set`. `wb_way` is the way index.
- R5: `wb_req` is a one-cycle pulse. Once it has pulsed, the block issues no further request until `wb_done` is seen. `clr_vld` pulses, with `clr_set`/`clr_way` naming the line just written, exactly one cycle after the cycle in which `wb_done` is high.
- R6: Each line written back has its dirty bit cleared. An immediately following walk therefore issues no writebacks.
- R7: `stall_fence` rises in the cycle after the request edge and falls when the walk ends. For a walk it stays high for exactly SETS*(1+2*WAYS) cycles, plus (2 + W) cycles for each writeback that waits W cycles for `wb_done`.
- R8: `stall_kind` encodes the winning stall cause: 5 for the walk, then 1 for `stall_causes[0]`, 2 for `[1]`, 3 for `[2]`, 4 for `[3]`, and 0 for none. The walk outranks every other cause, and among the other causes the lowest bit wins.
- R9: `tag_inv_we` follows `inv_req` while no walk is running, and is 0 while `flush_active` is high.
- R10: Request edges that arrive while a walk is running are ignored. They neither restart the walk nor lengthen it.
- R11: A `mark_vld` strobe sets the dirty bit of line (`mark_set`, `mark_way`), so that the next walk writes that line back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Fetch-synchronisation request level |
| inv_req | input | 1 | Tag invalidate request from the flush path |
| tag_inv_we | output | 1 | Gated tag invalidate write enable |
| mark_vld | input | 1 | Store path marks a line dirty |
| mark_set | input | SET_W | Set of the line being marked |
| mark_way | input | WAY_W | Way of the line being marked |
| tag_set | output | SET_W | Set index driven to the tag store |
| tag_rows | input | WAYS*TAG_W | Tags of all ways of `tag_set` |
| wb_req | output | 1 | Writeback request pulse |
| wb_addr | output | TAG_W+SET_W+OFF_W | Line address of the writeback |
| wb_way | output | WAY_W | Way being written back |
| wb_done | input | 1 | Memory reports that the write is complete |
| clr_vld | output | 1 | Dirty-clear strobe |
| clr_set | output | SET_W | Set being cleared |
| clr_way | output | WAY_W | Way being cleared |
| flush_active | output | 1 | A walk is in progress |
| stall_fence | output | 1 | Pipeline stall owned by the walk |
| stall_causes | input | 4 | Other stall causes (bit 0 has the highest priority) |
| stall_kind | output | 3 | Encoded winning stall cause |

## Verification
The assertions assume that memory raises `wb_done` only after at least one cycle of waiting and never while no request is outstanding. They also assume that `tag_rows` is a combinational view of the row selected by `tag_set`, and that the store path does not mark lines dirty while the stall is holding the pipeline. The bench's memory responder answers each request after a delay of one to three cycles, drives `tag_rows` from a fixed tag function of set and way, and issues marks only while the block is idle.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SCAN    = 3'd1,
        ST_CHECK   = 3'd2,
        ST_WB_REQ  = 3'd3,
        ST_WB_WAIT = 3'd4,
        ST_MARK    = 3'd5,
        ST_NEXT    = 3'd6,
        ST_DONE    = 3'd7
    } walk_state_e;

    typedef enum logic [2:0] {
        STALL_NONE = 3'd0,
        STALL_DMEM = 3'd1,
        STALL_IMEM = 3'd2,
        STALL_MUL  = 3'd3,
        STALL_DIV  = 3'd4,
        STALL_SYNC = 3'd5
    } stall_kind_e;

    localparam int N_CAUSES = 4;

    // The walk owns the pipeline in every state except idle and the final done cycle.
    function automatic logic walk_busy(walk_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/dfs_edge_det.sv
module dfs_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl && !lvl_q;
endmodule

// File: rtl/dfs_dirty_regs.sv
module dfs_dirty_regs #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mark_en,
    input  logic [SET_W-1:0] mark_set,
    input  logic [WAY_W-1:0] mark_way,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_set,
    input  logic [WAY_W-1:0] clr_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAYS-1:0]  rd_bits
);
    logic [SETS-1:0][WAYS-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (clr_en && clr_set == SET_W'(s) && clr_way == WAY_W'(w))
                        row_q[s][w] <= 1'b0;
                    if (mark_en && mark_set == SET_W'(s) && mark_way == WAY_W'(w))
                        row_q[s][w] <= 1'b1;
                end
            end
        end
    end

    assign rd_bits = row_q[rd_set];

    // Checker state: remembers the last clear that was not overridden by a mark.
    logic             pend_q;
    logic [SET_W-1:0] pset_q;
    logic [WAY_W-1:0] pway_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            pset_q <= '0;
            pway_q <= '0;
        end else begin
            pend_q <= clr_en && !(mark_en && mark_set == clr_set && mark_way == clr_way);
            pset_q <= clr_set;
            pway_q <= clr_way;
        end
    end

    // R6
    dirty_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !row_q[pset_q][pway_q]);
endmodule

// File: rtl/dfs_walk_fsm.sv
module dfs_walk_fsm
    import dfs_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             way_dirty,
    input  logic             wb_done,
    output walk_state_e      st_o,
    output logic [SET_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o,
    output logic             wb_req,
    output logic             clr_en,
    output logic             busy
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    walk_state_e      st_q, st_d;
    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (start) st_d = ST_SCAN;
            ST_SCAN:    st_d = ST_CHECK;
            ST_CHECK:   st_d = way_dirty ? ST_WB_REQ : ST_NEXT;
            ST_WB_REQ:  st_d = ST_WB_WAIT;
            ST_WB_WAIT: if (wb_done) st_d = ST_MARK;
            ST_MARK:    st_d = ST_NEXT;
            ST_NEXT: begin
                if (way_q != LAST_WAY)      st_d = ST_CHECK;
                else if (set_q != LAST_SET) st_d = ST_SCAN;
                else                        st_d = ST_DONE;
            end
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            set_q <= '0;
            way_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) begin
                set_q <= '0;
                way_q <= '0;
            end else if (st_q == ST_NEXT) begin
                if (way_q == LAST_WAY) begin
                    way_q <= '0;
                    if (set_q != LAST_SET) set_q <= set_q + 1'b1;
                end else begin
                    way_q <= way_q + 1'b1;
                end
            end
        end
    end

    assign st_o   = st_q;
    assign set_o  = set_q;
    assign way_o  = way_q;
    assign wb_req = (st_q == ST_WB_REQ);
    assign clr_en = (st_q == ST_MARK);
    assign busy   = walk_busy(st_q);

    // R5
    clr_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> $past(wb_done));

    // R5
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req |=> !wb_req);

    // R5
    line_held_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WB_WAIT) |-> ($stable(set_q) && $stable(way_q)));
endmodule

// File: rtl/dfs_stall_arb.sv
module dfs_stall_arb
    import dfs_pkg::*;
#(
    parameter int NC = N_CAUSES
) (
    input  logic          walk_stall,
    input  logic [NC-1:0] causes,
    output stall_kind_e   kind
);
    always_comb begin
        kind = STALL_NONE;
        for (int i = NC - 1; i >= 0; i--) begin
            if (causes[i]) kind = stall_kind_e'(3'(i + 1));
        end
        if (walk_stall) kind = STALL_SYNC;
    end
endmodule

// File: rtl/dline_flush_seq.sv
module dline_flush_seq
    import dfs_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int OFF_W = 5,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sync_req,
    input  logic                  inv_req,
    output logic                  tag_inv_we,
    input  logic                  mark_vld,
    input  logic [SET_W-1:0]      mark_set,
    input  logic [WAY_W-1:0]      mark_way,
    output logic [SET_W-1:0]      tag_set,
    input  logic [WAYS*TAG_W-1:0] tag_rows,
    output logic                  wb_req,
    output logic [ADDR_W-1:0]     wb_addr,
    output logic [WAY_W-1:0]      wb_way,
    input  logic                  wb_done,
    output logic                  clr_vld,
    output logic [SET_W-1:0]      clr_set,
    output logic [WAY_W-1:0]      clr_way,
    output logic                  flush_active,
    output logic                  stall_fence,
    input  logic [N_CAUSES-1:0]   stall_causes,
    output logic [2:0]            stall_kind
);
    logic             start;
    walk_state_e      st;
    logic [SET_W-1:0] set_idx;
    logic [WAY_W-1:0] way_idx;
    logic             clr_en;
    logic             busy;
    logic [WAYS-1:0]  rd_bits;
    logic [TAG_W-1:0] sel_tag;
    stall_kind_e      kind;

    dfs_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_req),
        .rise (start)
    );

    dfs_dirty_regs #(.SETS(SETS), .WAYS(WAYS)) u_dirty (
        .clk      (clk),
        .rst      (rst),
        .mark_en  (mark_vld),
        .mark_set (mark_set),
        .mark_way (mark_way),
        .clr_en   (clr_en),
        .clr_set  (set_idx),
        .clr_way  (way_idx),
        .rd_set   (set_idx),
        .rd_bits  (rd_bits)
    );

    dfs_walk_fsm #(.SETS(SETS), .WAYS(WAYS)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .way_dirty (rd_bits[way_idx]),
        .wb_done   (wb_done),
        .st_o      (st),
        .set_o     (set_idx),
        .way_o     (way_idx),
        .wb_req    (wb_req),
        .clr_en    (clr_en),
        .busy      (busy)
    );

    dfs_stall_arb #(.NC(N_CAUSES)) u_arb (
        .walk_stall (busy),
        .causes     (stall_causes),
        .kind       (kind)
    );

    assign sel_tag      = tag_rows[way_idx*TAG_W +: TAG_W];
    assign tag_set      = set_idx;
    assign wb_addr      = {sel_tag, set_idx, {OFF_W{1'b0}}};
    assign wb_way       = way_idx;
    assign clr_vld      = clr_en;
    assign clr_set      = set_idx;
    assign clr_way      = way_idx;
    assign flush_active = busy;
    assign stall_fence  = busy;
    assign tag_inv_we   = inv_req && !busy;
    assign stall_kind   = 3'(kind);

    // R3
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> rd_bits[way_idx]);

    // R7
    release_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush_active && $past(flush_active)) |-> (st == ST_DONE));

    // R8
    walk_outranks_chk: assert property (@(posedge clk) disable iff (rst)
        stall_fence |-> (stall_kind == 3'd5));

    // R9
    no_tag_inv_while_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB_WAIT) |-> !tag_inv_we);
endmodule

// File: tb/dline_flush_seq_tb.sv
module dline_flush_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 8;
    localparam int WAYS  = 4;
    localparam int TAG_W = 20;
    localparam int OFF_W = 5;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int ADDR_W = TAG_W + SET_W + OFF_W;
    localparam int CLEAN_WALK = SETS * (1 + 2 * WAYS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_req = 1'b0, inv_req = 1'b0, mark_vld = 1'b0, wb_done = 1'b0;
    logic [SET_W-1:0] mark_set = '0;
    logic [WAY_W-1:0] mark_way = '0;
    logic [3:0] stall_causes = '0;
    logic tag_inv_we, wb_req, clr_vld, flush_active, stall_fence;
    logic [SET_W-1:0] tag_set, clr_set;
    logic [WAY_W-1:0] wb_way, clr_way;
    logic [ADDR_W-1:0] wb_addr;
    logic [WAYS*TAG_W-1:0] tag_rows;
    logic [2:0] stall_kind;

    dline_flush_seq #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst(rst), .sync_req(sync_req), .inv_req(inv_req), .tag_inv_we(tag_inv_we),
        .mark_vld(mark_vld), .mark_set(mark_set), .mark_way(mark_way), .tag_set(tag_set),
        .tag_rows(tag_rows), .wb_req(wb_req), .wb_addr(wb_addr), .wb_way(wb_way),
        .wb_done(wb_done), .clr_vld(clr_vld), .clr_set(clr_set), .clr_way(clr_way),
        .flush_active(flush_active), .stall_fence(stall_fence), .stall_causes(stall_causes),
        .stall_kind(stall_kind)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [TAG_W-1:0] tag_of(int s, int w);
        return TAG_W'(32'h5A000 + s * 37 + w * 5);
    endfunction

    always_comb begin
        for (int w = 0; w < WAYS; w++) tag_rows[w*TAG_W +: TAG_W] = tag_of(int'(tag_set), w);
    end

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SET_W-1:0]  set;
        logic [WAY_W-1:0]  way;
    } wb_item_t;

    wb_item_t exp_q[$];
    bit model_dirty[SETS][WAYS];
    int n_checks = 0, n_fail = 0;
    int stall_cnt = 0, lat_sum = 0, wb_seen = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Monitor and memory responder: samples 2 time units after each rising edge.
    initial begin
        wb_item_t cur;
        bit outstanding = 0, done_pend = 0;
        int wait_cnt = 0;
        cur = '0;
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (stall_fence) stall_cnt++;
                if (done_pend) begin
                    chk("R5 clr_vld after done", clr_vld, 1);
                    chk("R5 clr_set", clr_set, cur.set);
                    chk("R5 clr_way", clr_way, cur.way);
                    wb_done = 1'b0;
                    done_pend = 0;
                    outstanding = 0;
                end else if (clr_vld) begin
                    chk("R5 clr_vld without done", clr_vld, 0);
                end
                if (wb_req) begin
                    if (outstanding) chk("R5 request while waiting", wb_req, 0);
                    if (exp_q.size() == 0) begin
                        chk("R3 unexpected writeback", wb_addr, 0);
                    end else begin
                        cur = exp_q.pop_front();
                        chk("R4 wb_addr", wb_addr, cur.addr);
                        chk("R4 wb_way", wb_way, cur.way);
                    end
                    outstanding = 1;
                    wait_cnt = 1 + (wb_seen % 3);
                    lat_sum += wait_cnt;
                    wb_seen++;
                end else if (outstanding && !done_pend) begin
                    wait_cnt--;
                    if (wait_cnt == 0) begin
                        wb_done = 1'b1;
                        done_pend = 1;
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic mark(int s, int w);
        @(negedge clk);
        mark_vld = 1'b1;
        mark_set = SET_W'(s);
        mark_way = WAY_W'(w);
        model_dirty[s][w] = 1;
        @(negedge clk);
        mark_vld = 1'b0;
    endtask

    // Driver: pushes the expected writebacks, starts a walk and checks its length.
    task automatic run_flush(bit mid_pulse, string label);
        int n = 0;
        int seen0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (model_dirty[s][w]) begin
                    exp_q.push_back('{addr: {tag_of(s, w), SET_W'(s), {OFF_W{1'b0}}},
                                      set: SET_W'(s), way: WAY_W'(w)});
                    model_dirty[s][w] = 0;
                    n++;
                end
        seen0 = wb_seen;
        @(negedge clk);
        sync_req = 1'b0;
        @(negedge clk);
        stall_cnt = 0;
        lat_sum = 0;
        sync_req = 1'b1;
        repeat (6) @(negedge clk);
        stall_causes = 4'b0001;
        inv_req = 1'b1;
        #1;
        chk({"R8 walk outranks dmem ", label}, stall_kind, 5);
        chk({"R9 inv blocked ", label}, tag_inv_we, 0);
        chk({"R7 stall raised ", label}, stall_fence, 1);
        stall_causes = 4'b0000;
        inv_req = 1'b0;
        if (mid_pulse) begin
            @(negedge clk);
            sync_req = 1'b0;
            @(negedge clk);
            sync_req = 1'b1;  // R10: edge during walk
        end
        while (stall_fence) @(negedge clk);
        inv_req = 1'b1;
        #1;
        chk({"R9 inv passes after walk ", label}, tag_inv_we, 1);
        inv_req = 1'b0;
        repeat (CLEAN_WALK + 8) @(negedge clk);
        chk({"R3 writeback count ", label}, wb_seen - seen0, n);
        chk({"R3 queue drained ", label}, exp_q.size(), 0);
        chk({"R7 R10 stall length ", label}, stall_cnt, CLEAN_WALK + 2 * n + lat_sum);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall_fence", stall_fence, 0);
        chk("R1 flush_active", flush_active, 0);
        chk("R1 wb_req", wb_req, 0);
        chk("R1 clr_vld", clr_vld, 0);
        chk("R1 stall_kind", stall_kind, 0);

        stall_causes = 4'b1010; #1; chk("R8 imem over div", stall_kind, 2);
        stall_causes = 4'b1100; #1; chk("R8 mul over div", stall_kind, 3);
        stall_causes = 4'b1000; #1; chk("R8 div alone", stall_kind, 4);
        stall_causes = 4'b1111; #1; chk("R8 dmem first", stall_kind, 1);
        stall_causes = 4'b0000;
        inv_req = 1'b1; #1; chk("R9 idle inv passes", tag_inv_we, 1);
        inv_req = 1'b0;

        run_flush(0, "R1 clean cache");

        // R11: marks, including first and last lines and a full set.
        mark(0, 0); mark(0, 3); mark(3, 1); mark(3, 2); mark(5, 0); mark(7, 3);
        for (int w = 0; w < WAYS; w++) mark(6, w);
        run_flush(1, "R11 R10 dirty walk");

        // R2: request stays high, no new walk.
        stall_cnt = 0;
        repeat (20) @(negedge clk);
        chk("R2 held level no restart", stall_cnt, 0);

        run_flush(0, "R6 after clear");

        mark(7, 3); mark(0, 0); mark(2, 2);
        run_flush(0, "R11 remark");

        finish_run();
    end
endmodule